// File: doc/BRIEF.md
# NAND Sector Single-Error Corrector

This block watches the bytes of one 512-byte flash sector as they stream past and folds them into a 24-bit parity code that can locate any single flipped data bit. When the sector has been streamed, a compare strobe takes the finished code, clears the running parity and compares the code with the 3-byte code that was stored beside the sector. One cycle later the block reports the code it computed, a four-way verdict and, when a data bit is bad, the byte offset and bit index to invert.

The code is made of two 12-bit halves. For every set data bit, the bit's address (byte index times eight plus bit index) is XORed into the high half and the address's complement into the low half. The code is inverted before output, so a fully erased sector (all 0xFF) gives an all-ones code and matches an all-ones stored code. The XOR of the computed and stored codes, the syndrome, separates a clean sector, one bad data bit, one bad bit in the stored code, and damage beyond repair. Writing the correction into a buffer is left to the caller.

Top module: `nand_ecc_corrector`

## Requirements
- R1: After reset `res_valid` is 0 and `res_code`, `res_status`, `err_byte` and `err_bit` are all 0.
- R2: For a streamed sector, `res_code` equals the inverse of {H, L}, where H is the XOR of the addresses byte*8+bit of every set data bit and L is the XOR of those addresses' 12-bit complements.
- R3: `res_code[11:0]` holds the inverted low half and `res_code[23:12]` the inverted high half; stored code byte 0 sits in bits 7:0. An all-0xFF sector gives 0xFFFFFF.
- R4: A syndrome (`res_code` XOR `stored_code`) of zero gives status 0 (clean).
- R5: If the syndrome's upper 12 bits XOR its lower 12 bits equal 0xFFF, status is 1 (data fix), `err_byte` is syndrome bits 23:15 and `err_bit` is syndrome bits 14:12.
- R6: A syndrome with exactly one bit set gives status 2 (stored-code error), with `err_byte` and `err_bit` 0.
- R7: Any other nonzero syndrome gives status 3 (uncorrectable), with `err_byte` and `err_bit` 0.
- R8: A syndrome of the R5 form whose byte offset is not below `SECTOR_BYTES` gives status 3.
- R9: The compare strobe clears the running parity and the byte counter, so the next bytes start again at index 0.
- R10: `start` discards the parity and byte count gathered so far; a byte valid in the same cycle becomes byte 0.
- R11: `res_valid` is high exactly in the cycle after a `cmp_strobe` cycle, for one cycle per strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Discard running parity and restart at byte 0 |
| in_valid | input | 1 | `in_data` carries a sector byte this cycle |
| in_data | input | 8 | Sector byte |
| cmp_strobe | input | 1 | Take the code, clear the parity and compare |
| stored_code | input | 24 | Code read from flash, byte 0 in bits 7:0 |
| res_valid | output | 1 | Result outputs are fresh this cycle |
| res_code | output | 24 | Computed code, byte 0 in bits 7:0 |
| res_status | output | 2 | 0 clean, 1 data fix, 2 stored-code error, 3 uncorrectable |
| err_byte | output | 9 | Byte offset of the bad bit when status is 1 |
| err_bit | output | 3 | Bit index of the bad bit when status is 1 |

## Verification
Random sectors compared against their own code separate a correct parity fold from any wrong address weighting, while the erased sector pins down the inversion and packing. Single data-bit flips at random places show that the reported offset and index come from the right syndrome bits; single and double flips in the stored code, plus double data flips, separate the stored-code verdict from the uncorrectable one. A directed syndrome whose offset lies past the sector end is fed to a default instance and to one built for a 256-byte sector, which must disagree; streams cut by a restart and streams with no restart after a compare show that stale parity and stale byte indexes are dropped.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN     = 2'd0,
    ST_FIXED     = 2'd1,
    ST_CODE_ONLY = 2'd2,
    ST_UNCORR    = 2'd3
  } ecc_status_e;

endpackage

// File: rtl/nand_ecc_fold.sv
// Running parity: each set bit folds its address into the high half and the
// complement of its address into the low half.
module nand_ecc_fold #(
  parameter int HALF_W = 12,
  localparam int BYTE_W = HALF_W - 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              snap,
  output logic [HALF_W-1:0] next_hi,
  output logic [HALF_W-1:0] next_lo
);

  logic [HALF_W-1:0] acc_hi, acc_lo;
  logic [BYTE_W-1:0] byte_cnt;
  logic [BYTE_W-1:0] idx;
  logic [2:0]        bit_xor;
  logic              odd;
  logic [HALF_W-1:0] part_hi, part_lo;

  assign idx = start ? '0 : byte_cnt;
  assign odd = ^in_data;

  always_comb begin
    bit_xor = '0;
    for (int k = 0; k < 8; k++) begin
      if (in_data[k]) bit_xor = bit_xor ^ 3'(k);
    end
  end

  // Odd bit count: the byte index survives the fold and the complement flips.
  assign part_hi = {(odd ? idx : '0), bit_xor};
  assign part_lo = part_hi ^ {HALF_W{odd}};

  always_comb begin
    next_hi = start ? '0 : acc_hi;
    next_lo = start ? '0 : acc_lo;
    if (in_valid) begin
      next_hi = next_hi ^ part_hi;
      next_lo = next_lo ^ part_lo;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || snap) begin
      acc_hi   <= '0;
      acc_lo   <= '0;
      byte_cnt <= '0;
    end else begin
      acc_hi   <= next_hi;
      acc_lo   <= next_lo;
      byte_cnt <= in_valid ? idx + 1'b1 : idx;
    end
  end

endmodule

// File: rtl/nand_ecc_pack.sv
// Joins the halves (low half in the low bits) and inverts the result.
module nand_ecc_pack #(
  parameter int HALF_W = 12,
  localparam int CODE_W = 2 * HALF_W
) (
  input  logic [HALF_W-1:0] hi,
  input  logic [HALF_W-1:0] lo,
  output logic [CODE_W-1:0] code
);

  assign code = ~{hi, lo};

endmodule

// File: rtl/nand_ecc_classify.sv
module nand_ecc_classify
  import nand_ecc_pkg::*;
#(
  parameter int HALF_W       = 12,
  parameter int SECTOR_BYTES = 512,
  localparam int CODE_W = 2 * HALF_W,
  localparam int BYTE_W = HALF_W - 3
) (
  input  logic [CODE_W-1:0] synd,
  output ecc_status_e       status,
  output logic [BYTE_W-1:0] loc_byte,
  output logic [2:0]        loc_bit
);

  localparam logic [BYTE_W:0] LIMIT = SECTOR_BYTES[BYTE_W:0];

  logic [HALF_W-1:0] half_mix;
  logic [BYTE_W-1:0] cand_byte;
  logic              single;

  assign half_mix  = synd[CODE_W-1:HALF_W] ^ synd[HALF_W-1:0];
  assign cand_byte = synd[CODE_W-1:HALF_W+3];
  assign single    = ((synd & (synd - 1'b1)) == '0);

  always_comb begin
    status   = ST_UNCORR;
    loc_byte = '0;
    loc_bit  = '0;
    if (synd == '0) begin
      status = ST_CLEAN;
    end else if (&half_mix) begin
      if ({1'b0, cand_byte} < LIMIT) begin
        status   = ST_FIXED;
        loc_byte = cand_byte;
        loc_bit  = synd[HALF_W+2:HALF_W];
      end
    end else if (single) begin
      status = ST_CODE_ONLY;
    end
  end

endmodule

// File: rtl/nand_ecc_corrector.sv
module nand_ecc_corrector
  import nand_ecc_pkg::*;
#(
  parameter int HALF_W       = 12,
  parameter int SECTOR_BYTES = 512,
  localparam int CODE_W = 2 * HALF_W,
  localparam int BYTE_W = HALF_W - 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              cmp_strobe,
  input  logic [CODE_W-1:0] stored_code,
  output logic              res_valid,
  output logic [CODE_W-1:0] res_code,
  output logic [1:0]        res_status,
  output logic [BYTE_W-1:0] err_byte,
  output logic [2:0]        err_bit
);

  logic [HALF_W-1:0] fold_hi, fold_lo;
  logic [CODE_W-1:0] code_now;
  ecc_status_e       verdict;
  logic [BYTE_W-1:0] fix_byte;
  logic [2:0]        fix_bit;

  nand_ecc_fold #(.HALF_W(HALF_W)) u_fold (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .in_valid (in_valid),
    .in_data  (in_data),
    .snap     (cmp_strobe),
    .next_hi  (fold_hi),
    .next_lo  (fold_lo)
  );

  nand_ecc_pack #(.HALF_W(HALF_W)) u_pack (
    .hi   (fold_hi),
    .lo   (fold_lo),
    .code (code_now)
  );

  nand_ecc_classify #(.HALF_W(HALF_W), .SECTOR_BYTES(SECTOR_BYTES)) u_classify (
    .synd     (code_now ^ stored_code),
    .status   (verdict),
    .loc_byte (fix_byte),
    .loc_bit  (fix_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_code   <= '0;
      res_status <= '0;
      err_byte   <= '0;
      err_bit    <= '0;
    end else begin
      res_valid <= cmp_strobe;
      if (cmp_strobe) begin
        res_code   <= code_now;
        res_status <= verdict;
        err_byte   <= fix_byte;
        err_bit    <= fix_bit;
      end
    end
  end

endmodule

// File: rtl/nand_ecc_checker.sv
module nand_ecc_checker #(
  parameter int HALF_W       = 12,
  parameter int SECTOR_BYTES = 512,
  localparam int CODE_W = 2 * HALF_W,
  localparam int BYTE_W = HALF_W - 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cmp_strobe,
  input logic [CODE_W-1:0] stored_code,
  input logic              res_valid,
  input logic [CODE_W-1:0] res_code,
  input logic [1:0]        res_status,
  input logic [BYTE_W-1:0] err_byte,
  input logic [2:0]        err_bit
);

  localparam logic [BYTE_W:0] LIMIT = SECTOR_BYTES[BYTE_W:0];

  logic [CODE_W-1:0] prev_stored;
  logic [CODE_W-1:0] synd;

  always_ff @(posedge clk) begin
    if (rst) prev_stored <= '0;
    else     prev_stored <= stored_code;
  end

  assign synd = res_code ^ prev_stored;

  assert_valid_after_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    cmp_strobe |=> res_valid);

  assert_valid_needs_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(cmp_strobe));

  assert_clean_match_R4: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_status == 2'd0) |-> (synd == '0));

  assert_fix_location_R5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_status == 2'd1) |->
      ({err_byte, err_bit} == synd[CODE_W-1:HALF_W] &&
       &(synd[CODE_W-1:HALF_W] ^ synd[HALF_W-1:0])));

  assert_fix_in_range_R8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_status == 2'd1) |-> ({1'b0, err_byte} < LIMIT));

  assert_code_only_R6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_status == 2'd2) |->
      ($countones(synd) == 1 && err_byte == '0 && err_bit == '0));

  assert_uncorr_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_status == 2'd3) |-> (synd != '0 && err_byte == '0));

endmodule

bind nand_ecc_corrector nand_ecc_checker #(
  .HALF_W(HALF_W), .SECTOR_BYTES(SECTOR_BYTES)
) u_checker (
  .clk         (clk),
  .rst         (rst),
  .cmp_strobe  (cmp_strobe),
  .stored_code (stored_code),
  .res_valid   (res_valid),
  .res_code    (res_code),
  .res_status  (res_status),
  .err_byte    (err_byte),
  .err_bit     (err_bit)
);

// File: tb/test_nand_ecc_corrector.sv
module test_nand_ecc_corrector;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        cmp_strobe = 1'b0;
  logic [23:0] stored_code = '0;

  logic        res_valid, res_valid_s;
  logic [23:0] res_code, res_code_s;
  logic [1:0]  res_status, res_status_s;
  logic [8:0]  err_byte, err_byte_s;
  logic [2:0]  err_bit, err_bit_s;

  int errors = 0;
  int checks = 0;
  logic [7:0] sec [512];

  always #2 clk = ~clk;

  nand_ecc_corrector i_nand_ecc_corrector (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .in_data(in_data),
    .cmp_strobe(cmp_strobe), .stored_code(stored_code),
    .res_valid(res_valid), .res_code(res_code), .res_status(res_status),
    .err_byte(err_byte), .err_bit(err_bit)
  );

  nand_ecc_corrector #(.SECTOR_BYTES(256)) i_nand_ecc_corrector_small (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .in_data(in_data),
    .cmp_strobe(cmp_strobe), .stored_code(stored_code),
    .res_valid(res_valid_s), .res_code(res_code_s), .res_status(res_status_s),
    .err_byte(err_byte_s), .err_bit(err_bit_s)
  );

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model_code(input int n);
    logic [11:0] hi = '0, lo = '0;
    for (int b = 0; b < n; b++)
      for (int k = 0; k < 8; k++)
        if (sec[b][k]) begin
          hi ^= 12'(b * 8 + k);
          lo ^= ~12'(b * 8 + k);
        end
    return ~{hi, lo};
  endfunction

  task automatic stream(input int n, input bit do_start);
    if (do_start) begin
      @(negedge clk); start = 1'b1; in_valid = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk); start = 1'b0; in_valid = 1'b1; in_data = sec[i];
    end
    @(negedge clk); start = 1'b0; in_valid = 1'b0;
  endtask

  task automatic compare(input logic [23:0] stored, input logic [23:0] exp_code,
                         input logic [1:0] exp_st, input logic [8:0] exp_byte,
                         input logic [2:0] exp_bit, input string req);
    @(negedge clk); cmp_strobe = 1'b1; stored_code = stored;
    @(negedge clk); cmp_strobe = 1'b0;
    check_eq({req, " R11 valid"}, 32'(res_valid), 32'd1);
    check_eq({req, " R2 code"}, 32'(res_code), 32'(exp_code));
    check_eq({req, " status"}, 32'(res_status), 32'(exp_st));
    check_eq({req, " byte"}, 32'(err_byte), 32'(exp_byte));
    check_eq({req, " bit"}, 32'(err_bit), 32'(exp_bit));
    @(negedge clk);
    check_eq({req, " R11 one cycle"}, 32'(res_valid), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [23:0] good;
    int b, k, j;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check_eq("R1 valid", 32'(res_valid), 0);
    check_eq("R1 code", 32'(res_code), 0);
    check_eq("R1 status", 32'(res_status), 0);
    check_eq("R1 loc", 32'({err_byte, err_bit}), 0);

    // R3 erased sector
    for (int i = 0; i < 512; i++) sec[i] = 8'hFF;
    stream(512, 1);
    compare(24'hFFFFFF, 24'hFFFFFF, 2'd0, 9'd0, 3'd0, "R3 erased R4");

    // R2/R4 random clean sectors
    for (int t = 0; t < 4; t++) begin
      for (int i = 0; i < 512; i++) sec[i] = 8'($urandom);
      good = model_code(512);
      stream(512, 1);
      compare(good, good, 2'd0, 9'd0, 3'd0, "R2 random clean R4");
    end

    // R5 single data-bit flips
    for (int t = 0; t < 5; t++) begin
      for (int i = 0; i < 512; i++) sec[i] = 8'($urandom);
      good = model_code(512);
      b = (t == 0) ? 511 : int'($urandom % 512);
      k = (t == 0) ? 7 : int'($urandom % 8);
      if (t == 1) begin b = 0; k = 0; end
      sec[b][k] = ~sec[b][k];
      stream(512, 1);
      compare(good, model_code(512), 2'd1, 9'(b), 3'(k), "R5 data flip");
    end

    // R6 single stored-code bit errors
    for (int t = 0; t < 3; t++) begin
      for (int i = 0; i < 512; i++) sec[i] = 8'($urandom);
      good = model_code(512);
      k = (t == 0) ? 23 : int'($urandom % 24);
      stream(512, 1);
      compare(good ^ (24'd1 << k), good, 2'd2, 9'd0, 3'd0, "R6 stored bit");
    end

    // R7 double stored-code error and double data error
    for (int i = 0; i < 512; i++) sec[i] = 8'($urandom);
    good = model_code(512);
    k = int'($urandom % 12);
    j = k + 12;
    stream(512, 1);
    compare(good ^ (24'd1 << k) ^ (24'd1 << j), good, 2'd3, 9'd0, 3'd0, "R7 two stored bits");
    sec[10][2] = ~sec[10][2];
    sec[300][5] = ~sec[300][5];
    stream(512, 1);
    compare(good, model_code(512), 2'd3, 9'd0, 3'd0, "R7 two data bits");

    // R9 strobe clears: empty compare, then stream without restart
    compare(24'hFFFFFF, 24'hFFFFFF, 2'd0, 9'd0, 3'd0, "R9 cleared parity");
    for (int i = 0; i < 512; i++) sec[i] = 8'($urandom);
    good = model_code(512);
    stream(512, 0);
    compare(good, good, 2'd0, 9'd0, 3'd0, "R9 counter cleared");

    // R10 restart drops a partial stream
    for (int i = 0; i < 40; i++) sec[i] = 8'($urandom);
    stream(40, 0);
    for (int i = 0; i < 512; i++) sec[i] = 8'($urandom);
    good = model_code(512);
    stream(512, 1);
    compare(good, good, 2'd0, 9'd0, 3'd0, "R10 restart");

    // R8 offset past the sector: syndrome {a, ~a}, a = byte 300 bit 3
    compare(24'hFFFFFF ^ {12'(300 * 8 + 3), ~12'(300 * 8 + 3)}, 24'hFFFFFF,
            2'd1, 9'd300, 3'd3, "R8 in range full");
    check_eq("R8 small instance status", 32'(res_status_s), 32'd3);
    check_eq("R8 small instance loc", 32'({err_byte_s, err_bit_s}), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule